// File: doc/BRIEF.md
# Stream Buffer Prefetch Unit

This unit sits beside a cache and keeps a small set of stream buffers. Each buffer remembers a run of consecutive block addresses that have been fetched ahead of demand. Every request the cache sees is presented to the unit in the same cycle, together with the cache's hit or miss result. The unit compares the block address against all buffers in parallel and reports whether one of them can supply the block. When neither the cache nor any buffer holds the block, it reports that a new stream has begun. After accepting a request it issues prefetch reads to the next memory level, one address per cycle.

A buffer is either entirely full or treated as empty: a single valid flag per buffer covers all of its slots. A miss in the cache and in every buffer takes over the least recently used buffer and fills it with the blocks that follow the requested one. A cache miss that hits a buffer supplies the block from that buffer. That buffer then slides forward so that it again holds the next `DEPTH` blocks after the requested one, and only the blocks it did not already hold are fetched. While a refill is in progress the unit is busy and ignores requests. Memory timing is outside the block: each prefetch address is taken to be accepted in the cycle it is shown.

Top module: `stream_prefetcher`

## Requirements
- R1: After reset no buffer is valid, `busy` and `pf_valid` are low, and replacement order begins with buffer `NUM_BUF-1`, then `NUM_BUF-2`, down to buffer 0.
- R2: A request matches buffer b when b is valid and the unsigned difference `req_addr - base(b)`, taken modulo 2^ADDR_W, is below `DEPTH`. The buffer's base is its lowest held block.
- R3: An accepted request with `cache_hit` low and no match raises `stream_new` in the same cycle, with `buf_sel` set to the least recently used buffer. In the following `DEPTH` cycles `pf_valid` and `busy` are high and `pf_addr` steps through X+1 up to X+DEPTH, one address per cycle. After that both signals are low.
- R4: An accepted request with `cache_hit` low that matches a buffer at offset k raises `sb_hit` in the same cycle, with `buf_sel` set to that buffer. In the following k+1 cycles `pf_addr` steps from base+DEPTH up to base+DEPTH+k. The buffer then holds X+1 up to X+DEPTH.
- R5: An accepted request with `cache_hit` high that matches a buffer raises neither `sb_hit` nor `stream_new`, issues no prefetch and leaves all buffers unchanged. It still marks that buffer as most recently used.
- R6: An accepted request with `cache_hit` high and no match has no effect on outputs, buffer contents or replacement order.
- R7: When several buffers match, the lowest-indexed one is used.
- R8: Replacement order is updated on every stream creation and every buffer match, and a new stream always takes the buffer whose last use is oldest.
- R9: A buffer's valid flag is cleared when its refill starts and set after its last prefetch is issued. A buffer that is being refilled matches no request.
- R10: A request presented while `busy` is high is ignored. It raises no output, does not disturb the prefetch sequence in progress and changes no buffer state.
- R11: Block addresses and buffer ranges wrap modulo 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A cache request is present this cycle |
| req_addr | input | ADDR_W | Block address of the request |
| cache_hit | input | 1 | The cache lookup for this request hit |
| busy | output | 1 | A refill is in progress; requests are ignored |
| sb_hit | output | 1 | Cache missed and a buffer supplies the block |
| stream_new | output | 1 | Cache and all buffers missed; a new stream starts |
| buf_sel | output | $clog2(NUM_BUF) | Buffer used, meaningful when `sb_hit` or `stream_new` is high |
| pf_valid | output | 1 | A prefetch read is issued this cycle |
| pf_addr | output | ADDR_W | Block address of the prefetch read |

## Verification
The hardest case to reach from the ports is a request that overlaps more than one valid buffer. Only a single buffer is written at a time, and each buffer always holds a contiguous run. The stimulus builds the overlap on purpose: it opens one stream, then opens a second one a couple of blocks lower, so that two ranges share addresses, and then misses on a shared block. Replacement order is made visible by letting later stream creations reveal which buffer was chosen. A request injected in the middle of a refill, aimed at the buffer being refilled, shows that busy requests are ignored. A long pseudo-random run over a narrow address window hits every offset and every buffer many times.

// File: rtl/stream_prefetcher.sv
module stream_prefetcher #(
  parameter int NUM_BUF = 4,
  parameter int DEPTH   = 4,
  parameter int ADDR_W  = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  input  logic [ADDR_W-1:0]           req_addr,
  input  logic                        cache_hit,
  output logic                        busy,
  output logic                        sb_hit,
  output logic                        stream_new,
  output logic [$clog2(NUM_BUF)-1:0]  buf_sel,
  output logic                        pf_valid,
  output logic [ADDR_W-1:0]           pf_addr
);

  localparam int IDX_W = $clog2(NUM_BUF);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [ADDR_W-1:0] base_q [NUM_BUF];
  logic [IDX_W-1:0]  rank_q [NUM_BUF];
  logic [ADDR_W-1:0] offs   [NUM_BUF];
  logic [NUM_BUF-1:0] valid_q, match, victim;
  logic [IDX_W-1:0]  hit_idx, vic_idx, touch_idx, fill_idx;
  logic [ADDR_W-1:0] next_q;
  logic [CNT_W-1:0]  remain_q;
  logic              busy_q, accept, any_match, touch;

  for (genvar g = 0; g < NUM_BUF; g++) begin : g_look
    assign offs[g]   = req_addr - base_q[g];
    assign match[g]  = valid_q[g] && (offs[g] < ADDR_W'(DEPTH));
    assign victim[g] = (rank_q[g] == IDX_W'(NUM_BUF - 1));
  end

  always_comb begin
    hit_idx = '0;
    vic_idx = '0;
    for (int i = NUM_BUF - 1; i >= 0; i--) begin
      if (match[i])  hit_idx = IDX_W'(i);
      if (victim[i]) vic_idx = IDX_W'(i);
    end
  end

  assign accept     = req_valid && !busy_q;
  assign any_match  = |match;
  assign sb_hit     = accept && !cache_hit && any_match;
  assign stream_new = accept && !cache_hit && !any_match;
  assign touch      = accept && (any_match || !cache_hit);
  assign touch_idx  = any_match ? hit_idx : vic_idx;
  assign buf_sel    = touch_idx;
  assign busy       = busy_q;
  assign pf_valid   = busy_q;
  assign pf_addr    = next_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q  <= '0;
      busy_q   <= 1'b0;
      fill_idx <= '0;
      next_q   <= '0;
      remain_q <= '0;
      for (int i = 0; i < NUM_BUF; i++) begin
        base_q[i] <= '0;
        rank_q[i] <= IDX_W'(i);
      end
    end else begin
      if (busy_q) begin
        next_q   <= next_q + 1'b1;
        remain_q <= remain_q - 1'b1;
        if (remain_q == CNT_W'(1)) begin
          busy_q            <= 1'b0;
          valid_q[fill_idx] <= 1'b1;
        end
      end else if (stream_new) begin
        base_q[vic_idx]  <= req_addr + 1'b1;
        valid_q[vic_idx] <= 1'b0;
        busy_q           <= 1'b1;
        fill_idx         <= vic_idx;
        next_q           <= req_addr + 1'b1;
        remain_q         <= CNT_W'(DEPTH);
      end else if (sb_hit) begin
        base_q[hit_idx]  <= req_addr + 1'b1;
        valid_q[hit_idx] <= 1'b0;
        busy_q           <= 1'b1;
        fill_idx         <= hit_idx;
        next_q           <= base_q[hit_idx] + ADDR_W'(DEPTH);
        remain_q         <= CNT_W'(offs[hit_idx]) + 1'b1;
      end
      if (touch) begin
        for (int i = 0; i < NUM_BUF; i++) begin
          if (IDX_W'(i) == touch_idx)
            rank_q[i] <= '0;
          else if (rank_q[i] < rank_q[touch_idx])
            rank_q[i] <= rank_q[i] + 1'b1;
        end
      end
    end
  end

  a_r3_new_starts_fill: assert property (@(posedge clk) disable iff (!rst_n)
    stream_new |=> busy && pf_addr == $past(req_addr) + 1'b1);

  a_r3_addr_steps: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> pf_addr == $past(pf_addr) + 1'b1);

  a_r4_hit_starts_fill: assert property (@(posedge clk) disable iff (!rst_n)
    sb_hit |=> busy && !valid_q[$past(hit_idx)]);

  a_r8_single_lru: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(victim) == 1);

  a_r9_valid_after_fill: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> valid_q[fill_idx]);

  a_r9_filling_not_valid: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !valid_q[fill_idx] && !match[fill_idx]);

endmodule

// File: tb/stream_prefetcher_tb_top.sv
module stream_prefetcher_tb_top;
  localparam int N  = 4;
  localparam int M  = 4;
  localparam int AW = 12;

  logic clk = 0, rst_n = 0, req_valid = 0, cache_hit = 0;
  logic [AW-1:0] req_addr = '0;
  logic busy, sb_hit, stream_new, pf_valid;
  logic [1:0] buf_sel;
  logic [AW-1:0] pf_addr;

  int checks = 0, errors = 0, now = N;
  logic [AW-1:0] mb [N];
  bit mv [N];
  int ms [N];

  always #5 clk = ~clk;

  stream_prefetcher #(.NUM_BUF(N), .DEPTH(M), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .cache_hit(cache_hit), .busy(busy), .sb_hit(sb_hit), .stream_new(stream_new),
    .buf_sel(buf_sel), .pf_valid(pf_valid), .pf_addr(pf_addr));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int find_match(input logic [AW-1:0] x);
    for (int i = 0; i < N; i++) begin
      logic [AW-1:0] d;
      d = x - mb[i];
      if (mv[i] && d < AW'(M)) return i;
    end
    return -1;
  endfunction

  function automatic int oldest();
    int v = 0;
    for (int i = 1; i < N; i++) if (ms[i] < ms[v]) v = i;
    return v;
  endfunction

  task automatic do_req(input logic [AW-1:0] x, input bit ch, input string tag,
                        input bit inj = 0, input logic [AW-1:0] ix = '0);
    int mi, sel, cnt;
    bit eh, en;
    logic [AW-1:0] first, d;
    mi = find_match(x);
    eh = 0; en = 0; cnt = 0; sel = 0; first = '0;
    if (!ch) begin
      if (mi >= 0) begin
        d = x - mb[mi];
        eh = 1; sel = mi; cnt = int'(d) + 1; first = mb[mi] + AW'(M);
      end else begin
        en = 1; sel = oldest(); cnt = M; first = x + 1'b1;
      end
    end else if (mi >= 0) sel = mi;
    @(negedge clk);
    req_valid = 1; req_addr = x; cache_hit = ch;
    #1;
    check(sb_hit == eh, {tag, " sb_hit"}, int'(sb_hit), int'(eh));
    check(stream_new == en, {tag, " stream_new"}, int'(stream_new), int'(en));
    if (eh || en) check(int'(buf_sel) == sel, {tag, " buf_sel"}, int'(buf_sel), sel);
    if (mi >= 0 || !ch) begin now++; ms[sel] = now; end
    if (!ch) begin mb[sel] = x + 1'b1; mv[sel] = 0; end
    @(negedge clk);
    req_valid = 0;
    for (int i = 0; i < cnt; i++) begin
      logic [AW-1:0] e;
      e = first + AW'(i);
      check(pf_valid && busy && pf_addr == e, {tag, " pf_addr"}, int'(pf_addr), int'(e));
      if (inj && i == 1) begin
        req_valid = 1; req_addr = ix; cache_hit = 0;
        #1;
        check(!sb_hit && !stream_new, "R10 busy request ignored", int'(sb_hit | stream_new), 0);
      end
      @(negedge clk);
      req_valid = 0;
    end
    check(!busy && !pf_valid, {tag, " idle after fill"}, int'(busy), 0);
    if (!ch) mv[sel] = 1;
  endtask

  initial begin
    #2ms;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    for (int i = 0; i < N; i++) begin mb[i] = '0; mv[i] = 0; ms[i] = N - 1 - i; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!busy && !pf_valid, "R1 reset idle", int'(busy | pf_valid), 0);
    check(!sb_hit && !stream_new, "R1 reset outputs", int'(sb_hit | stream_new), 0);

    do_req(12'h100, 0, "R1 R3 first stream");
    do_req(12'h200, 0, "R1 R3 second stream");
    do_req(12'h300, 0, "R1 third stream");
    do_req(12'h400, 0, "R1 fourth stream");
    do_req(12'h101, 1, "R5 cache hit in buffer");
    do_req(12'h500, 0, "R5 R8 victim after touch");
    do_req(12'h777, 1, "R6 cache hit no match");
    do_req(12'h780, 0, "R6 R8 order unchanged");
    do_req(12'h302, 0, "R2 R4 hit offset 1");
    do_req(12'h306, 0, "R4 R9 hit offset 3 after refill");
    do_req(12'h600, 0, "R7 setup stream A");
    do_req(12'h5FE, 0, "R7 setup stream B");
    do_req(12'h601, 0, "R7 lowest index wins");
    do_req(12'hFFE, 0, "R11 wrap stream");
    do_req(12'h001, 0, "R11 wrap hit");
    for (int k = 0; k < M; k++) begin
      logic [AW-1:0] b;
      b = 12'h900 + AW'(k * 16);
      do_req(b, 0, "R3 offset sweep create");
      do_req(b + 1'b1 + AW'(k), 0, "R4 offset sweep hit");
    end
    do_req(12'hA00, 0, "R10 R9 inject during fill", 1, 12'hA02);
    do_req(12'hA02, 0, "R10 state kept after inject");
    lf = 16'hACE1;
    for (int n = 0; n < 400; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      do_req(12'h040 + AW'(lf[4:0]), lf[7] & lf[9], "R2 R8 sweep");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule